// File: doc/BRIEF.md
# Serial Channel Byte Buffer with DMA Request Signaling

This block holds the byte queues of one asynchronous serial channel. Bytes from the deserializer land in a receive queue that the host drains. Bytes the host writes wait in a transmit queue until the serializer takes them. After reset each queue holds a single character. Setting an enable bit turns both queues into 16-deep FIFOs. A programmable fill threshold on the receive side raises a data-available interrupt.

Two request outputs pace a DMA engine, one per direction. Single-transfer signaling is the default. It asks for service one byte at a time: receive while anything is held, transmit only when the queue is empty. Burst signaling asks for receive service once the threshold is reached and keeps asking until the queue drains. It asks for transmit service while there is room.

The host side and the serializer side use valid/ready. A byte moves on a cycle where both are high. `tx_in_ready` falls when the transmit queue is full, so the host must hold its byte. `rx_out_valid` and `tx_out_valid` fall when their queue is empty, and a ready with no valid moves nothing. The deserializer push has no back-pressure, because a serial line cannot be paused. A byte it offers to a full receive queue is lost and recorded in an overrun flag.

Top module: `chan_fifo_core`

## Requirements
- R1: After reset the block is in single-character mode with single-transfer signaling and a threshold of one byte. Both queues are empty. Outputs: `rx_irq`=0, `rx_dma_req`=0, `tx_dma_req`=1, `rx_overrun`=0, `rx_out_valid`=0, `tx_in_ready`=1.
- R2: A write with `cfg_we` loads the control fields from `cfg_wdata`. Bit 0 enables FIFO mode. Bit 1 flushes the receive queue. Bit 2 flushes the transmit queue. Bit 3 selects burst signaling. Bits 5:4 select the threshold: 0 → 1 byte, 1 → 4, 2 → 8, 3 → 14. The two flush bits act only on that write and are not stored.
- R3: In FIFO mode each queue holds 16 bytes in arrival order. A receive push to a full queue is dropped, even if a pop happens in the same cycle, and sets `rx_overrun`. `rx_overrun` stays set until a `stat_rd` cycle in which no new drop occurs.
- R4: In single-character mode each queue holds one byte. The threshold acts as one byte and signaling acts as single-transfer, whatever the stored fields say.
- R5: `rx_irq` is high exactly while the receive fill is at or above the threshold. It falls as soon as the fill drops below it.
- R6: With single-transfer signaling, `rx_dma_req` is high exactly while the receive queue holds at least one byte.
- R7: With burst signaling, `rx_dma_req` rises when the receive fill reaches the threshold. It stays high until the receive queue is empty.
- R8: With single-transfer signaling, `tx_dma_req` is high only while the transmit queue is empty.
- R9: With burst signaling, `tx_dma_req` is high while the transmit queue has space. It is low when the queue is full.
- R10: A write that changes the FIFO-enable bit, in either direction, empties both queues. Each flush bit empties only its own queue.
- R11: A pop from an empty receive queue changes nothing. `rx_out_data` keeps showing the last byte popped, and a flush does not change it.
- R12: `rx_out_valid` and `tx_out_valid` are high while their queue is not empty. `tx_in_ready` is low while the transmit queue is full. A transmit write made while `tx_in_ready` is low is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 6 | Control write data (fields in R2) |
| stat_rd | input | 1 | Status read strobe, clears overrun |
| rx_in_valid | input | 1 | Deserializer byte present |
| rx_in_data | input | DW | Deserializer byte |
| rx_out_valid | output | 1 | Receive queue not empty |
| rx_out_ready | input | 1 | Host pops a receive byte |
| rx_out_data | output | DW | Receive head, or last popped byte when empty |
| tx_in_valid | input | 1 | Host offers a transmit byte |
| tx_in_ready | output | 1 | Transmit queue has room |
| tx_in_data | input | DW | Host transmit byte |
| tx_out_valid | output | 1 | Transmit queue not empty |
| tx_out_ready | input | 1 | Serializer takes a byte |
| tx_out_data | output | DW | Transmit head |
| rx_irq | output | 1 | Receive data available interrupt |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_overrun | output | 1 | Sticky receive drop flag |

## Verification
The bench uses the default parameters: 8-bit data and a depth of 16. At that depth the 14-byte threshold sits two bytes below full. One run can therefore cross the threshold, fill the queue, and force a dropped byte. The quarter and half thresholds land on 4 and 8, and the table reaches them in a few pushes. The capacity-of-one case lets the overrun and full-queue paths of single-character mode show up after just two operations.

// File: rtl/chan_buf_pkg.sv
package chan_buf_pkg;
  // control word bit positions
  localparam int CFG_EN      = 0;
  localparam int CFG_RXFLUSH = 1;
  localparam int CFG_TXFLUSH = 2;
  localparam int CFG_BURST   = 3;
  localparam int CFG_TRIG_LO = 4;
  localparam int CFG_W       = 6;

  typedef enum logic [1:0] {
    TRIG_ONE     = 2'd0,
    TRIG_QUARTER = 2'd1,
    TRIG_HALF    = 2'd2,
    TRIG_NEAR    = 2'd3
  } trig_sel_e;

  typedef struct packed {
    logic      fifo_en;
    logic      burst;
    trig_sel_e trig;
  } cfg_t;
endpackage

// File: rtl/chan_byte_queue.sv
module chan_byte_queue #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [CW-1:0] limit,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [DW-1:0] last_q;
  logic          push_ok, pop_ok;

  assign full    = (count >= limit);
  assign empty   = (count == '0);
  assign push_ok = push & ~full & ~clr;
  assign pop_ok  = pop & ~empty & ~clr;
  assign head    = empty ? last_q : mem[rd_ptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      last_q <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok) begin
        rd_ptr <= bump(rd_ptr);
        last_q <= mem[rd_ptr];
      end
      case ({push_ok, pop_ok})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/chan_ctrl_regs.sv
module chan_ctrl_regs
  import chan_buf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output cfg_t             cfg_q,
  output logic             rx_clr,
  output logic             tx_clr
);
  logic en_flip;

  // a change of the enable bit empties both queues
  assign en_flip = cfg_we & (cfg_wdata[CFG_EN] != cfg_q.fifo_en);
  assign rx_clr  = en_flip | (cfg_we & cfg_wdata[CFG_RXFLUSH]);
  assign tx_clr  = en_flip | (cfg_we & cfg_wdata[CFG_TXFLUSH]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q.fifo_en <= 1'b0;
      cfg_q.burst   <= 1'b0;
      cfg_q.trig    <= TRIG_ONE;
    end else if (cfg_we) begin
      cfg_q.fifo_en <= cfg_wdata[CFG_EN];
      cfg_q.burst   <= cfg_wdata[CFG_BURST];
      cfg_q.trig    <= trig_sel_e'(cfg_wdata[CFG_TRIG_LO+1:CFG_TRIG_LO]);
    end
  end
endmodule

// File: rtl/chan_dma_flags.sv
module chan_dma_flags
  import chan_buf_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  cfg_t          cfg_q,
  input  logic [CW-1:0] rx_cnt,
  input  logic [CW-1:0] tx_cnt,
  input  logic [CW-1:0] tx_cap,
  output logic          rx_irq,
  output logic          rx_req,
  output logic          tx_req
);
  localparam logic [CW-1:0] LVL_QUARTER = CW'(DEPTH / 4);
  localparam logic [CW-1:0] LVL_HALF    = CW'(DEPTH / 2);
  localparam logic [CW-1:0] LVL_NEAR    = CW'(DEPTH - 2);

  logic [CW-1:0] lvl;
  logic          burst_eff, at_lvl, rx_any, hold_q;

  always_comb begin
    case (cfg_q.trig)
      TRIG_ONE:     lvl = CW'(1);
      TRIG_QUARTER: lvl = LVL_QUARTER;
      TRIG_HALF:    lvl = LVL_HALF;
      default:      lvl = LVL_NEAR;
    endcase
    if (!cfg_q.fifo_en) lvl = CW'(1);
  end

  assign burst_eff = cfg_q.fifo_en & cfg_q.burst;
  assign at_lvl    = (rx_cnt >= lvl);
  assign rx_any    = (rx_cnt != '0);

  // burst receive request latches at threshold, releases on empty
  always_ff @(posedge clk) begin
    if (!rst_n)      hold_q <= 1'b0;
    else if (!rx_any) hold_q <= 1'b0;
    else if (at_lvl)  hold_q <= 1'b1;
  end

  assign rx_irq = at_lvl;
  assign rx_req = burst_eff ? ((at_lvl | hold_q) & rx_any) : rx_any;
  assign tx_req = burst_eff ? (tx_cnt < tx_cap) : (tx_cnt == '0);
endmodule

// File: rtl/chan_fifo_core.sv
module chan_fifo_core
  import chan_buf_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             stat_rd,
  input  logic             rx_in_valid,
  input  logic [DW-1:0]    rx_in_data,
  output logic             rx_out_valid,
  input  logic             rx_out_ready,
  output logic [DW-1:0]    rx_out_data,
  input  logic             tx_in_valid,
  output logic             tx_in_ready,
  input  logic [DW-1:0]    tx_in_data,
  output logic             tx_out_valid,
  input  logic             tx_out_ready,
  output logic [DW-1:0]    tx_out_data,
  output logic             rx_irq,
  output logic             rx_dma_req,
  output logic             tx_dma_req,
  output logic             rx_overrun
);
  cfg_t          cfg_q;
  logic          rx_clr, tx_clr;
  logic [CW-1:0] cap, rx_cnt, tx_cnt;
  logic          rx_full, rx_empty, tx_full, tx_empty;
  logic          ovr_q;

  // single-character mode shrinks each queue to one slot
  assign cap = cfg_q.fifo_en ? CW'(DEPTH) : CW'(1);

  chan_ctrl_regs u_ctrl (
    .clk, .rst_n, .cfg_we, .cfg_wdata,
    .cfg_q, .rx_clr, .tx_clr
  );

  chan_byte_queue #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
    .clk, .rst_n, .clr(rx_clr), .limit(cap),
    .push(rx_in_valid), .push_data(rx_in_data), .pop(rx_out_ready),
    .head(rx_out_data), .count(rx_cnt), .full(rx_full), .empty(rx_empty)
  );

  chan_byte_queue #(.DW(DW), .DEPTH(DEPTH)) u_txq (
    .clk, .rst_n, .clr(tx_clr), .limit(cap),
    .push(tx_in_valid), .push_data(tx_in_data), .pop(tx_out_ready),
    .head(tx_out_data), .count(tx_cnt), .full(tx_full), .empty(tx_empty)
  );

  chan_dma_flags #(.DEPTH(DEPTH)) u_flags (
    .clk, .rst_n, .cfg_q, .rx_cnt, .tx_cnt, .tx_cap(cap),
    .rx_irq, .rx_req(rx_dma_req), .tx_req(tx_dma_req)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                               ovr_q <= 1'b0;
    else if (rx_in_valid & rx_full & ~rx_clr) ovr_q <= 1'b1;
    else if (stat_rd)                         ovr_q <= 1'b0;
  end

  assign rx_overrun   = ovr_q;
  assign rx_out_valid = ~rx_empty;
  assign tx_out_valid = ~tx_empty;
  assign tx_in_ready  = ~tx_full;
endmodule

// File: rtl/chan_fifo_core_chk.sv
module chan_fifo_core_chk #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic          wr_en_bit,
  input logic          fifo_en,
  input logic          burst,
  input logic [CW-1:0] rx_cnt,
  input logic [CW-1:0] tx_cnt,
  input logic          rx_in_valid,
  input logic          rx_out_valid,
  input logic          rx_out_ready,
  input logic [DW-1:0] rx_out_data,
  input logic          tx_out_valid,
  input logic          rx_dma_req,
  input logic          tx_dma_req,
  input logic          rx_overrun
);
  logic [CW-1:0] cap_now;
  logic          mode1;
  assign cap_now = fifo_en ? CW'(DEPTH) : CW'(1);
  assign mode1   = fifo_en & burst;

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= CW'(DEPTH) && tx_cnt <= CW'(DEPTH));

  // R4
  char_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |-> (rx_cnt <= CW'(1) && tx_cnt <= CW'(1)));

  // R3
  drop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_in_valid && rx_cnt >= cap_now && !cfg_we) |=> rx_overrun);

  // R10
  mode_flip_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && wr_en_bit != fifo_en) |=> (rx_cnt == '0 && tx_cnt == '0));

  // R11
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_out_ready && !rx_out_valid && !rx_in_valid) |=> $stable(rx_out_data));

  // R6
  rx_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode1 |-> (rx_dma_req == rx_out_valid));

  // R8
  tx_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode1 && tx_dma_req) |-> !tx_out_valid);

  // R7
  rx_burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode1 && rx_dma_req && !cfg_we) ##1 (mode1 && rx_out_valid) |-> rx_dma_req);
endmodule

bind chan_fifo_core chan_fifo_core_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .wr_en_bit(cfg_wdata[0]),
  .fifo_en(cfg_q.fifo_en), .burst(cfg_q.burst),
  .rx_cnt(rx_cnt), .tx_cnt(tx_cnt), .rx_in_valid(rx_in_valid),
  .rx_out_valid(rx_out_valid), .rx_out_ready(rx_out_ready),
  .rx_out_data(rx_out_data), .tx_out_valid(tx_out_valid),
  .rx_dma_req(rx_dma_req), .tx_dma_req(tx_dma_req), .rx_overrun(rx_overrun)
);

// File: tb/chan_fifo_core_test.sv
`timescale 1ns/1ps
module chan_fifo_core_test;
  localparam int DW = 8;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [5:0] cfg_wdata = '0;
  logic stat_rd = 1'b0;
  logic rx_in_valid = 1'b0;
  logic [DW-1:0] rx_in_data = '0;
  logic rx_out_valid, rx_out_ready = 1'b0;
  logic [DW-1:0] rx_out_data;
  logic tx_in_valid = 1'b0, tx_in_ready;
  logic [DW-1:0] tx_in_data = '0;
  logic tx_out_valid, tx_out_ready = 1'b0;
  logic [DW-1:0] tx_out_data;
  logic rx_irq, rx_dma_req, tx_dma_req, rx_overrun;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  chan_fifo_core #(.DW(DW), .DEPTH(DEPTH)) uut (
    .clk, .rst_n, .cfg_we, .cfg_wdata, .stat_rd,
    .rx_in_valid, .rx_in_data, .rx_out_valid, .rx_out_ready, .rx_out_data,
    .tx_in_valid, .tx_in_ready, .tx_in_data, .tx_out_valid, .tx_out_ready,
    .tx_out_data, .rx_irq, .rx_dma_req, .tx_dma_req, .rx_overrun
  );

  // ops: 0 idle, 1 cfg write, 2 rx push, 3 rx pop, 4 tx write, 5 tx pop, 6 status read
  // entry: op[25:22] arg[21:14] flags{irq,rxreq,txreq,ovr}[13:10] dsel[9:8] data[7:0]
  // dsel: 0 none, 1 rx_out_data, 2 tx_out_data
  localparam int NV = 30;
  localparam logic [25:0] VEC [NV] = '{
    {4'd2, 8'h11, 4'b1110, 2'd1, 8'h11},
    {4'd2, 8'h22, 4'b1111, 2'd1, 8'h11},
    {4'd6, 8'h00, 4'b1110, 2'd1, 8'h11},
    {4'd3, 8'h00, 4'b0010, 2'd1, 8'h11},
    {4'd3, 8'h00, 4'b0010, 2'd1, 8'h11},
    {4'd4, 8'hA5, 4'b0000, 2'd2, 8'hA5},
    {4'd4, 8'h5A, 4'b0000, 2'd2, 8'hA5},
    {4'd5, 8'h00, 4'b0010, 2'd0, 8'h00},
    {4'd1, 8'h01, 4'b0010, 2'd1, 8'h11},
    {4'd1, 8'h19, 4'b0010, 2'd0, 8'h00},
    {4'd2, 8'h31, 4'b0010, 2'd1, 8'h31},
    {4'd2, 8'h32, 4'b0010, 2'd1, 8'h31},
    {4'd2, 8'h33, 4'b0010, 2'd1, 8'h31},
    {4'd2, 8'h34, 4'b1110, 2'd1, 8'h31},
    {4'd3, 8'h00, 4'b0110, 2'd1, 8'h32},
    {4'd3, 8'h00, 4'b0110, 2'd1, 8'h33},
    {4'd3, 8'h00, 4'b0110, 2'd1, 8'h34},
    {4'd3, 8'h00, 4'b0010, 2'd1, 8'h34},
    {4'd2, 8'h41, 4'b0010, 2'd1, 8'h41},
    {4'd1, 8'h1B, 4'b0010, 2'd1, 8'h34},
    {4'd1, 8'h01, 4'b0010, 2'd0, 8'h00},
    {4'd2, 8'h51, 4'b1110, 2'd1, 8'h51},
    {4'd4, 8'h61, 4'b1100, 2'd2, 8'h61},
    {4'd4, 8'h62, 4'b1100, 2'd2, 8'h61},
    {4'd5, 8'h00, 4'b1100, 2'd2, 8'h62},
    {4'd5, 8'h00, 4'b1110, 2'd0, 8'h00},
    {4'd4, 8'h71, 4'b1100, 2'd2, 8'h71},
    {4'd1, 8'h05, 4'b1110, 2'd1, 8'h51},
    {4'd1, 8'h00, 4'b0010, 2'd1, 8'h34},
    {4'd0, 8'h00, 4'b0010, 2'd1, 8'h34}
  };

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // inputs change just after a falling edge; outputs are read at the next one
  task automatic step(input logic [3:0] op, input logic [7:0] arg);
    case (op)
      4'd1: begin cfg_we = 1'b1; cfg_wdata = arg[5:0]; end
      4'd2: begin rx_in_valid = 1'b1; rx_in_data = arg; end
      4'd3: rx_out_ready = 1'b1;
      4'd4: begin tx_in_valid = 1'b1; tx_in_data = arg; end
      4'd5: tx_out_ready = 1'b1;
      4'd6: stat_rd = 1'b1;
      default: ;
    endcase
    @(negedge clk);
    cfg_we = 1'b0; rx_in_valid = 1'b0; rx_out_ready = 1'b0;
    tx_in_valid = 1'b0; tx_out_ready = 1'b0; stat_rd = 1'b0;
  endtask

  task automatic reset_check();
    check("R1 rx_irq", {31'd0, rx_irq}, 32'd0);
    check("R1 rx_dma_req", {31'd0, rx_dma_req}, 32'd0);
    check("R1 tx_dma_req", {31'd0, tx_dma_req}, 32'd1);
    check("R1 rx_overrun", {31'd0, rx_overrun}, 32'd0);
    check("R1 rx_out_valid", {31'd0, rx_out_valid}, 32'd0);
    check("R1 tx_in_ready", {31'd0, tx_in_ready}, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    reset_check();

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [25:0] v;
      v = VEC[i];
      step(v[25:22], v[21:14]);
      check($sformatf("vec %0d flags R2 R4 R5 R6 R7 R8 R9 R10", i),
            {28'd0, rx_irq, rx_dma_req, tx_dma_req, rx_overrun}, {28'd0, v[13:10]});
      if (v[9:8] == 2'd1)
        check($sformatf("vec %0d rx data R3 R10 R11", i), {24'd0, rx_out_data}, {24'd0, v[7:0]});
      else if (v[9:8] == 2'd2)
        check($sformatf("vec %0d tx data R3 R4 R12", i), {24'd0, tx_out_data}, {24'd0, v[7:0]});
    end

    // threshold 14, burst, fill to full and overrun
    step(4'd1, 8'h39);
    for (int i = 0; i < 13; i++) step(4'd2, 8'h80 + 8'(i));
    check("R5 below 14", {31'd0, rx_irq}, 32'd0);
    check("R7 below 14", {31'd0, rx_dma_req}, 32'd0);
    step(4'd2, 8'h8D);
    check("R5 at 14", {31'd0, rx_irq}, 32'd1);
    check("R7 at 14", {31'd0, rx_dma_req}, 32'd1);
    step(4'd2, 8'h8E);
    step(4'd2, 8'h8F);
    check("R3 full no drop yet", {31'd0, rx_overrun}, 32'd0);
    step(4'd2, 8'hEE);
    check("R3 overrun set", {31'd0, rx_overrun}, 32'd1);
    step(4'd0, 8'h00);
    check("R3 overrun sticky", {31'd0, rx_overrun}, 32'd1);
    step(4'd6, 8'h00);
    check("R3 overrun cleared", {31'd0, rx_overrun}, 32'd0);
    for (int i = 0; i < 16; i++) begin
      check("R3 rx order", {24'd0, rx_out_data}, {24'd0, 8'h80 + 8'(i)});
      step(4'd3, 8'h00);
      if (i == 14) begin
        check("R7 hold until empty", {31'd0, rx_dma_req}, 32'd1);
        check("R5 falls below level", {31'd0, rx_irq}, 32'd0);
      end
    end
    check("R12 rx drained", {31'd0, rx_out_valid}, 32'd0);
    check("R7 released on empty", {31'd0, rx_dma_req}, 32'd0);

    // threshold 8
    step(4'd1, 8'h29);
    for (int i = 0; i < 7; i++) step(4'd2, 8'h20 + 8'(i));
    check("R5 seven below 8", {31'd0, rx_irq}, 32'd0);
    step(4'd2, 8'h27);
    check("R5 eight reaches 8", {31'd0, rx_irq}, 32'd1);
    step(4'd1, 8'h2B);
    check("R10 rx flush", {31'd0, rx_out_valid}, 32'd0);

    // transmit in burst mode up to full
    for (int i = 0; i < 15; i++) step(4'd4, 8'hC0 + 8'(i));
    check("R9 space left", {31'd0, tx_dma_req}, 32'd1);
    check("R12 ready with space", {31'd0, tx_in_ready}, 32'd1);
    step(4'd4, 8'hCF);
    check("R9 full", {31'd0, tx_dma_req}, 32'd0);
    check("R12 not ready when full", {31'd0, tx_in_ready}, 32'd0);
    step(4'd4, 8'hFF);
    for (int i = 0; i < 16; i++) begin
      check("R3 tx order", {24'd0, tx_out_data}, {24'd0, 8'hC0 + 8'(i)});
      step(4'd5, 8'h00);
    end
    check("R12 dropped write absent", {31'd0, tx_out_valid}, 32'd0);
    check("R9 empty has space", {31'd0, tx_dma_req}, 32'd1);

    // reset from a busy state
    step(4'd2, 8'h99);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    reset_check();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule